// File: doc/BRIEF.md
# Register Access Sequencer

This block sits between client logic and a multiplexed-bus transceiver, so that a client can read or write one peripheral register with a single request and one response. The client offers a request with an address, a direction and, for writes, a data byte. The sequencer copies these into its transceiver-facing registers and waits a fixed number of settle cycles so that those lines are quiet. It then gives the transceiver a one-cycle start pulse and waits for the transceiver's completion pulse. Finally it answers the client with a one-cycle response pulse, which carries the read byte when the request was a read.

An auto-read request always reads the fixed receive-auto-read register, whatever address the client offers. Clients use it to walk through received packet bytes one at a time.

The request side follows valid/ready rules. A request is taken in a cycle where `req_valid` and `req_ready` are both high. While `req_ready` is low, a valid request is not taken and has no effect. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse that the client must accept when it comes.

Top module: `regseq`

## Requirements
- R1: After reset `req_ready` is 1 and `busy`, `xcv_start`, `rsp_valid` and `rsp_rdata` are 0.
- R2: A read request (`req_write`=0, `req_auto`=0) drives `xcv_rnw` high and `xcv_addr` to the request address while `xcv_start` is high.
- R3: A write request (`req_write`=1, `req_auto`=0) drives `xcv_rnw` low, `xcv_addr` to the request address and `xcv_wdata` to the request data while `xcv_start` is high.
- R4: For a request taken at clock edge k, the transceiver outputs take their new values at edge k+1. `xcv_start` is high for the single cycle after edge k+1+SETTLE_CYC, and the outputs do not change in the cycle before it.
- R5: An auto-read request (`req_auto`=1) presents address AUTO_ADDR (default 0x01) and ignores `req_addr`.
- R6: `xcv_start` is a one-cycle pulse. The sequencer then waits for `xcv_done` for as many cycles as the transceiver takes.
- R7: `rsp_valid` is high for exactly the one cycle after the edge that samples `xcv_done`. On a read, `rsp_rdata` takes the `xcv_rdata` sampled at that edge and holds it. A write leaves `rsp_rdata` unchanged.
- R8: `busy` is high from the accepting edge through the `rsp_valid` cycle, and `req_ready` is its inverse. Requests offered while busy are ignored: they cause no extra start and do not change the transceiver outputs.
- R9: `req_auto`=1 forces a read even when `req_write`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client offers a request |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_auto | input | 1 | 1 = auto-read at the fixed address |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data byte |
| busy | output | 1 | An access is in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last read byte |
| xcv_addr | output | ADDR_W | Address to transceiver |
| xcv_rnw | output | 1 | Direction to transceiver, 1 = read |
| xcv_wdata | output | DATA_W | Write data to transceiver |
| xcv_start | output | 1 | Start pulse to transceiver |
| xcv_done | input | 1 | Completion pulse from transceiver |
| xcv_rdata | input | DATA_W | Read byte from transceiver |

## Verification
The tests apply a plain read, a write, and an auto-read with a conflicting client address and the write bit set. Together these separate the direction rules from the address override. Transceiver latencies of 1, 2 and 5 cycles show whether the sequencer really waits for the completion pulse rather than a fixed count. Counting the cycles from acceptance to start pins down the settle delay exactly. A write placed between two reads shows that read data is held and is not overwritten. Requests offered while busy show whether anything leaks into a second start or an address change.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOAD   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_START  = 3'd3,
    ST_WAIT   = 3'd4,
    ST_RESP   = 3'd5
  } seq_state_t;
endpackage

// File: rtl/regseq_param_reg.sv
module regseq_param_reg #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] AUTO_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              load_en,
  input  logic              req_write,
  input  logic              req_auto,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              held_auto,
  output logic [ADDR_W-1:0] xcv_addr,
  output logic              xcv_rnw,
  output logic [DATA_W-1:0] xcv_wdata
);
  logic              h_write;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_wdata;

  // capture the request at the accepting edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_write   <= 1'b0;
      held_auto <= 1'b0;
      h_addr    <= '0;
      h_wdata   <= '0;
    end else if (accept) begin
      h_write   <= req_write;
      held_auto <= req_auto;
      h_addr    <= req_addr;
      h_wdata   <= req_wdata;
    end
  end

  // transceiver-facing lines change only in the load step
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xcv_addr  <= '0;
      xcv_rnw   <= 1'b1;
      xcv_wdata <= '0;
    end else if (load_en) begin
      xcv_addr  <= held_auto ? AUTO_ADDR : h_addr;
      xcv_rnw   <= held_auto | ~h_write;
      xcv_wdata <= h_wdata;
    end
  end

  AST_AUTO_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_en) && held_auto |-> xcv_rnw); // R9
endmodule

// File: rtl/regseq_settle_timer.sv
module regseq_settle_timer #(
  parameter int CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (clear)           cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end

  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt < CW'(CYC)); // R4
endmodule

// File: rtl/regseq_fsm.sv
module regseq_fsm
  import regseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              settle_done,
  input  logic              xcv_done,
  input  logic              is_read,
  input  logic [DATA_W-1:0] xcv_rdata,
  output logic              req_ready,
  output logic              busy,
  output logic              accept,
  output logic              load_en,
  output logic              timer_clear,
  output logic              timer_run,
  output logic              xcv_start,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  seq_state_t st, st_nx;

  assign req_ready   = (st == ST_IDLE);
  assign busy        = ~req_ready;
  assign accept      = req_ready & req_valid;
  assign load_en     = (st == ST_LOAD);
  assign timer_clear = load_en;
  assign timer_run   = (st == ST_SETTLE);
  assign xcv_start   = (st == ST_START);
  assign rsp_valid   = (st == ST_RESP);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:   if (req_valid)   st_nx = ST_LOAD;
      ST_LOAD:                    st_nx = ST_SETTLE;
      ST_SETTLE: if (settle_done) st_nx = ST_START;
      ST_START:                   st_nx = ST_WAIT;
      ST_WAIT:   if (xcv_done)    st_nx = ST_RESP;
      ST_RESP:                    st_nx = ST_IDLE;
      default:                    st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rsp_rdata <= '0;
    else if (st == ST_WAIT && xcv_done && is_read)
      rsp_rdata <= xcv_rdata;
  end

  AST_RSP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(xcv_done)); // R7
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_rdata)); // R7
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xcv_start |=> !xcv_start); // R6
  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid)); // R8
endmodule

// File: rtl/regseq.sv
module regseq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SETTLE_CYC = 3,
  parameter logic [ADDR_W-1:0] AUTO_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_auto,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] xcv_addr,
  output logic              xcv_rnw,
  output logic [DATA_W-1:0] xcv_wdata,
  output logic              xcv_start,
  input  logic              xcv_done,
  input  logic [DATA_W-1:0] xcv_rdata
);
  logic accept, load_en, t_clear, t_run, t_exp, held_auto;

  regseq_param_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AUTO_ADDR(AUTO_ADDR)) u_prm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .load_en(load_en),
    .req_write(req_write), .req_auto(req_auto), .req_addr(req_addr),
    .req_wdata(req_wdata), .held_auto(held_auto),
    .xcv_addr(xcv_addr), .xcv_rnw(xcv_rnw), .xcv_wdata(xcv_wdata)
  );

  regseq_settle_timer #(.CYC(SETTLE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear(t_clear), .run(t_run), .expired(t_exp)
  );

  regseq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .settle_done(t_exp),
    .xcv_done(xcv_done), .is_read(xcv_rnw), .xcv_rdata(xcv_rdata),
    .req_ready(req_ready), .busy(busy), .accept(accept), .load_en(load_en),
    .timer_clear(t_clear), .timer_run(t_run), .xcv_start(xcv_start),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  AST_LINES_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    xcv_start |-> $stable(xcv_addr) && $stable(xcv_rnw) && $stable(xcv_wdata)); // R4
  AST_AUTO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    xcv_start && held_auto |-> xcv_addr == AUTO_ADDR); // R5
  AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    xcv_start |-> busy); // R8
endmodule

// File: tb/test_regseq.sv
module test_regseq;
  localparam int SETTLE = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_auto = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic req_ready, busy, rsp_valid, xcv_rnw, xcv_start;
  logic [7:0] rsp_rdata, xcv_addr, xcv_wdata;
  logic xcv_done = 1'b0;
  logic [7:0] xcv_rdata = '0;
  int checks = 0, errs = 0, cyc = 0;

  always #4 clk = ~clk; // 125 MHz

  regseq #(.SETTLE_CYC(SETTLE)) i_regseq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_auto(req_auto), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .xcv_addr(xcv_addr), .xcv_rnw(xcv_rnw),
    .xcv_wdata(xcv_wdata), .xcv_start(xcv_start), .xcv_done(xcv_done),
    .xcv_rdata(xcv_rdata)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // one full access; transceiver modelled here with latency lat (>=1)
  task automatic run_op(input logic wr, input logic au, input logic [7:0] a,
                        input logic [7:0] wd, input logic [7:0] rd, input int lat,
                        input logic [7:0] exp_addr, input logic exp_rnw,
                        input logic [7:0] exp_rdata, input logic pester);
    int n;
    logic [7:0] a_seen;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_auto = au; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = pester; req_addr = ~a;  // pester: keep offering while busy
    chk(busy && !req_ready, "R8 busy after accept", busy, 1);
    n = 0;
    while (!xcv_start && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(n == SETTLE + 1, "R4 settle delay", n, SETTLE + 1);
    chk(xcv_addr == exp_addr, "R2/R5 address", xcv_addr, exp_addr);
    chk(xcv_rnw == exp_rnw, "R3/R9 direction", xcv_rnw, exp_rnw);
    if (!exp_rnw) chk(xcv_wdata == wd, "R3 write data", xcv_wdata, wd);
    a_seen = xcv_addr;
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      if (i == 0) chk(!xcv_start, "R6 start one cycle", xcv_start, 0);
      if (i == lat - 1) req_valid = 0;
    end
    chk(!rsp_valid && busy, "R6 waits for done", rsp_valid, 0);
    if (pester) chk(xcv_addr == a_seen, "R8 busy request ignored", xcv_addr, a_seen);
    xcv_done = 1; xcv_rdata = rd;
    @(negedge clk);
    xcv_done = 0; xcv_rdata = 8'hEE;
    chk(rsp_valid, "R7 response pulse", rsp_valid, 1);
    chk(rsp_rdata == exp_rdata, "R7 read data", rsp_rdata, exp_rdata);
    @(negedge clk);
    chk(!rsp_valid && !busy && req_ready, "R7/R8 back to idle", rsp_valid, 0);
    chk(rsp_rdata == exp_rdata, "R7 data held", rsp_rdata, exp_rdata);
    if (pester) begin
      @(negedge clk);
      chk(!xcv_start && !busy, "R8 no extra start", xcv_start, 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !busy, "R1 idle after reset", busy, 0);
    chk(!xcv_start && !rsp_valid, "R1 no pulses", xcv_start, 0);
    chk(rsp_rdata == 0, "R1 read data cleared", rsp_rdata, 0);
  endtask

  task automatic t_read();  run_op(0, 0, 8'h5A, 8'h00, 8'hC3, 2, 8'h5A, 1, 8'hC3, 0); endtask
  task automatic t_write(); run_op(1, 0, 8'h33, 8'h7E, 8'h99, 5, 8'h33, 0, 8'hC3, 0); endtask
  task automatic t_auto();  run_op(1, 1, 8'hF0, 8'h55, 8'h11, 1, 8'h01, 1, 8'h11, 0); endtask
  task automatic t_busy();  run_op(0, 0, 8'h42, 8'h00, 8'hA5, 3, 8'h42, 1, 8'hA5, 1); endtask

  initial begin
    t_reset();
    t_read();
    t_write();
    t_auto();
    t_busy();
    t_read();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule